// File: doc/BRIEF.md
# Debug Memory Window Decoder

This block sits behind a debug or program-loader port. For each transfer request it looks at a flat 32-bit byte address and picks one of three memory spaces: instruction memory, data memory, or a unified memory split into 128 KiB segments. It then reports the chosen space, the byte offset inside that space and, for unified accesses, the segment number. It also rejects requests that cannot be served. A request is a single-cycle strobe with an address, a byte length and a write flag. The answer comes one cycle later as a done pulse, with the decoded fields and an error flag.

Address bits 25:24 choose the space. Each space has its own offset width and its own length ceiling. A unified transfer is never checked against a segment boundary and is never split; the memory side handles any spill-over. The memories are not part of this block.

Top module: `dbgwin_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, `done`, `err` and `sel` are 0 and `offset` and `segment` are 0.
- R2: `done` is high for exactly the one cycle after each cycle where `req` is high, and is low otherwise. `err`, `sel`, `offset`, `segment` and `wr_o` are all 0 whenever `done` is low.
- R3: Bits 25:24 = 00 select unified memory. `sel` = 3'b100, `offset` = addr[16:0] and `segment` = addr[31:17].
- R4: Bits 25:24 = 10 select data memory. `sel` = 3'b010, `offset` = addr[15:0] (bits 23:16 are ignored) and `segment` = 0.
- R5: Bits 25:24 = 01 select instruction memory. `sel` = 3'b001, `offset` = addr[17:0] and `segment` = 0.
- R6: Bits 25:24 = 11 are rejected. `err` = 1, `sel` = 0, `offset` = 0 and `segment` = 0.
- R7: A data-memory request with length above 32768 bytes is rejected (`err` = 1, all fields 0). A length of exactly 32768 is accepted.
- R8: An instruction-memory request with length above 262144 bytes is rejected. A length of exactly 262144 is accepted.
- R9: A unified request is accepted at any length, including one that runs past the end of its segment.
- R10: `wr_o` repeats the `wr` value of the request alongside `done`, for accepted requests and for rejected ones.
- R11: Address bits 31:26 have no effect on which space is chosen. For data and instruction spaces they do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle request strobe |
| wr | input | 1 | 1 = write transfer, 0 = read |
| addr | input | 32 | Flat byte address |
| len | input | 20 | Transfer length in bytes |
| done | output | 1 | Response pulse, one cycle after `req` |
| err | output | 1 | Request rejected (valid with `done`) |
| wr_o | output | 1 | Echoed write flag |
| sel | output | 3 | One-hot space: bit0 instruction, bit1 data, bit2 unified |
| offset | output | 18 | Byte offset inside the selected space |
| segment | output | 15 | Unified segment number |

## Verification
The bench drives lengths exactly at each ceiling and one byte above it. A design that used `>=` in place of `>` would reject the exact 32 KiB data or 256 KiB instruction transfer; a design that checked the wrong space's limit would reject or accept the wrong request. High address bits are set on data, instruction and unified addresses. A decoder that compared more than bits 25:24 would send these to the wrong space. A unified transfer that crosses a segment end must still be accepted. Back-to-back strobes test that `done` follows each request and never stretches or drops one.

// File: rtl/dbgwin_pkg.sv
package dbgwin_pkg;
  // Encoding equals address bits 25:24; the decoder relies on this order.
  typedef enum logic [1:0] {
    SP_UNIFIED = 2'b00,
    SP_INSTR   = 2'b01,
    SP_DATA    = 2'b10,
    SP_INVALID = 2'b11
  } space_e;

  localparam int SEL_W   = 3;
  localparam int SEL_INS = 0;
  localparam int SEL_DAT = 1;
  localparam int SEL_UNI = 2;
endpackage

// File: rtl/dbgwin_space_dec.sv
module dbgwin_space_dec
  import dbgwin_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SPACE_LSB = 24,
  parameter int UOFF_W    = 17,
  parameter int DOFF_W    = 16,
  parameter int IOFF_W    = 18,
  parameter int OFF_W     = 18,
  parameter int SEG_W     = ADDR_W - UOFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output space_e            space,
  output logic [OFF_W-1:0]  off,
  output logic [SEG_W-1:0]  seg
);
  always_comb begin
    space = space_e'(addr[SPACE_LSB+1:SPACE_LSB]);
    off   = '0;
    seg   = '0;
    unique case (space)
      SP_UNIFIED: begin
        off = OFF_W'(addr[UOFF_W-1:0]);
        seg = addr[ADDR_W-1:UOFF_W];
      end
      SP_DATA:  off = OFF_W'(addr[DOFF_W-1:0]);
      SP_INSTR: off = OFF_W'(addr[IOFF_W-1:0]);
      default:  off = '0;
    endcase
  end
endmodule

// File: rtl/dbgwin_len_chk.sv
module dbgwin_len_chk
  import dbgwin_pkg::*;
#(
  parameter int LEN_W        = 20,
  parameter int DATA_MAX_LEN = 32768,
  parameter int INST_MAX_LEN = 262144
) (
  input  space_e            space,
  input  logic [LEN_W-1:0]  len,
  output logic              reject
);
  logic data_long, inst_long;

  assign data_long = len > LEN_W'(DATA_MAX_LEN);
  assign inst_long = len > LEN_W'(INST_MAX_LEN);

  always_comb begin
    unique case (space)
      SP_DATA:    reject = data_long;
      SP_INSTR:   reject = inst_long;
      SP_INVALID: reject = 1'b1;
      default:    reject = 1'b0;   // unified: no ceiling, no split
    endcase
  end
endmodule

// File: rtl/dbgwin_resp_reg.sv
module dbgwin_resp_reg
  import dbgwin_pkg::*;
#(
  parameter int OFF_W = 18,
  parameter int SEG_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             wr,
  input  space_e           space,
  input  logic             reject,
  input  logic [OFF_W-1:0] off_in,
  input  logic [SEG_W-1:0] seg_in,
  output logic             done,
  output logic             err,
  output logic             wr_o,
  output logic [SEL_W-1:0] sel,
  output logic [OFF_W-1:0] offset,
  output logic [SEG_W-1:0] segment
);
  logic [SEL_W-1:0] sel_nx;

  always_comb begin
    sel_nx = '0;
    unique case (space)
      SP_INSTR:   sel_nx[SEL_INS] = 1'b1;
      SP_DATA:    sel_nx[SEL_DAT] = 1'b1;
      SP_UNIFIED: sel_nx[SEL_UNI] = 1'b1;
      default:    sel_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      err     <= 1'b0;
      wr_o    <= 1'b0;
      sel     <= '0;
      offset  <= '0;
      segment <= '0;
    end else begin
      done    <= req;
      err     <= req & reject;
      wr_o    <= req & wr;
      sel     <= (req && !reject) ? sel_nx : '0;
      offset  <= (req && !reject) ? off_in : '0;
      segment <= (req && !reject) ? seg_in : '0;
    end
  end

  assert_done_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req |=> done);
  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (rst)
    !req |=> !done);
  assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!err && sel == '0 && offset == '0 && segment == '0));
  assert_accept_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ($countones(sel) == 1));
  assert_reject_clears_R6: assert property (@(posedge clk) disable iff (rst)
    err |-> (sel == '0 && offset == '0 && segment == '0));
  assert_seg_only_unified_R4: assert property (@(posedge clk) disable iff (rst)
    !sel[SEL_UNI] |-> (segment == '0));
endmodule

// File: rtl/dbgwin_decoder.sv
module dbgwin_decoder
  import dbgwin_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SPACE_LSB    = 24,
  parameter int UOFF_W       = 17,
  parameter int DOFF_W       = 16,
  parameter int IOFF_W       = 18,
  parameter int LEN_W        = 20,
  parameter int DATA_MAX_LEN = 32768,
  parameter int INST_MAX_LEN = 262144,
  localparam int OFF_W = (IOFF_W > UOFF_W) ? ((IOFF_W > DOFF_W) ? IOFF_W : DOFF_W)
                                           : ((UOFF_W > DOFF_W) ? UOFF_W : DOFF_W),
  localparam int SEG_W = ADDR_W - UOFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              done,
  output logic              err,
  output logic              wr_o,
  output logic [SEL_W-1:0]  sel,
  output logic [OFF_W-1:0]  offset,
  output logic [SEG_W-1:0]  segment
);
  space_e           space;
  logic [OFF_W-1:0] off_c;
  logic [SEG_W-1:0] seg_c;
  logic             reject;

  dbgwin_space_dec #(
    .ADDR_W(ADDR_W), .SPACE_LSB(SPACE_LSB), .UOFF_W(UOFF_W),
    .DOFF_W(DOFF_W), .IOFF_W(IOFF_W), .OFF_W(OFF_W), .SEG_W(SEG_W)
  ) u_dec (
    .addr(addr), .space(space), .off(off_c), .seg(seg_c)
  );

  dbgwin_len_chk #(
    .LEN_W(LEN_W), .DATA_MAX_LEN(DATA_MAX_LEN), .INST_MAX_LEN(INST_MAX_LEN)
  ) u_chk (
    .space(space), .len(len), .reject(reject)
  );

  dbgwin_resp_reg #(
    .OFF_W(OFF_W), .SEG_W(SEG_W)
  ) u_resp (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .space(space), .reject(reject),
    .off_in(off_c), .seg_in(seg_c), .done(done), .err(err), .wr_o(wr_o),
    .sel(sel), .offset(offset), .segment(segment)
  );

  assert_wr_echo_R10: assert property (@(posedge clk) disable iff (rst)
    req |=> (wr_o == $past(wr)));
  assert_bad_space_err_R6: assert property (@(posedge clk) disable iff (rst)
    (req && addr[SPACE_LSB+1:SPACE_LSB] == 2'b11) |=> err);
  assert_data_ceiling_R7: assert property (@(posedge clk) disable iff (rst)
    (req && addr[SPACE_LSB+1:SPACE_LSB] == 2'b10 && len > LEN_W'(DATA_MAX_LEN)) |=> err);
  assert_unified_never_err_R9: assert property (@(posedge clk) disable iff (rst)
    (req && addr[SPACE_LSB+1:SPACE_LSB] == 2'b00) |=> !err);
endmodule

// File: tb/dbgwin_decoder_test.sv
module dbgwin_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        wr  = 1'b0;
  logic [31:0] addr = '0;
  logic [19:0] len  = '0;
  logic        done, err, wr_o;
  logic [2:0]  sel;
  logic [17:0] offset;
  logic [14:0] segment;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dbgwin_decoder uut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .len(len),
    .done(done), .err(err), .wr_o(wr_o), .sel(sel), .offset(offset),
    .segment(segment)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [31:0] a;
    logic [19:0] n;
    logic        w;
    logic        e;
    logic [2:0]  s;
    logic [17:0] o;
    logic [14:0] g;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  32'h0002_1234, 20'd4,      1'b0, 1'b0, 3'b100, 18'h01234, 15'h0001}, // R3
    '{4'd3,  32'h00FF_FFFF, 20'd100,    1'b1, 1'b0, 3'b100, 18'h1FFFF, 15'h007F}, // R3
    '{4'd11, 32'hFC00_0010, 20'd2,      1'b0, 1'b0, 3'b100, 18'h00010, 15'h7E00}, // R11
    '{4'd7,  32'h0200_ABCD, 20'd32768,  1'b1, 1'b0, 3'b010, 18'h0ABCD, 15'h0000}, // R7
    '{4'd7,  32'h0200_0000, 20'd32769,  1'b0, 1'b1, 3'b000, 18'h00000, 15'h0000}, // R7
    '{4'd4,  32'h0203_4567, 20'd2,      1'b0, 1'b0, 3'b010, 18'h04567, 15'h0000}, // R4
    '{4'd8,  32'h0103_FFFC, 20'd262144, 1'b0, 1'b0, 3'b001, 18'h3FFFC, 15'h0000}, // R8
    '{4'd8,  32'h0100_0000, 20'd262145, 1'b1, 1'b1, 3'b000, 18'h00000, 15'h0000}, // R8
    '{4'd6,  32'h0300_0000, 20'd1,      1'b0, 1'b1, 3'b000, 18'h00000, 15'h0000}, // R6
    '{4'd6,  32'hFF00_0004, 20'd1,      1'b1, 1'b1, 3'b000, 18'h00000, 15'h0000}, // R6, R10
    '{4'd9,  32'h0001_FFF0, 20'd65536,  1'b0, 1'b0, 3'b100, 18'h1FFF0, 15'h0000}, // R9
    '{4'd5,  32'h4100_0020, 20'd8,      1'b1, 1'b0, 3'b001, 18'h00020, 15'h0000}  // R5, R11
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [19:0] n, input logic w);
    @(negedge clk);
    req = 1'b1; addr = a; len = n; wr = w;
    @(negedge clk);
    req = 1'b0; addr = '0; len = '0; wr = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {done, err, sel, offset, segment}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {done, err, sel, offset, segment}, '0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].a, VECS[i].n, VECS[i].w);
      check($sformatf("R%0d vec%0d done", VECS[i].rq, i), done, 1'b1);
      check($sformatf("R%0d vec%0d err", VECS[i].rq, i), err, VECS[i].e);
      check($sformatf("R%0d vec%0d sel", VECS[i].rq, i), sel, VECS[i].s);
      check($sformatf("R%0d vec%0d offset", VECS[i].rq, i), offset, VECS[i].o);
      check($sformatf("R%0d vec%0d segment", VECS[i].rq, i), segment, VECS[i].g);
      check($sformatf("R10 vec%0d wr_o", i), wr_o, VECS[i].w);
    end

    // R2: done drops after one cycle, fields clear
    @(negedge clk);
    check("R2 done single cycle", {done, err, wr_o, sel, offset, segment}, '0);

    // R2: back-to-back requests, one done per request
    @(negedge clk);
    req = 1'b1; addr = 32'h0100_0040; len = 20'd4; wr = 1'b1;
    @(negedge clk);
    check("R2 b2b first done", {done, sel, offset}, {1'b1, 3'b001, 18'h00040});
    addr = 32'h0200_0080; len = 20'd4; wr = 1'b0;
    @(negedge clk);
    req = 1'b0; addr = '0; len = '0;
    check("R2 b2b second done", {done, wr_o, sel, offset}, {1'b1, 1'b0, 3'b010, 18'h00080});
    @(negedge clk);
    check("R2 b2b idle", done, 1'b0);

    // R7: zero length on data space accepted
    issue(32'h0200_0002, 20'd0, 1'b0);
    check("R7 zero len", {err, sel}, {1'b0, 3'b010});

    // R9: maximum length on unified accepted
    issue(32'h00FE_0000, 20'hFFFFF, 1'b1);
    check("R9 max len", {err, sel, segment}, {1'b0, 3'b100, 15'h007F});

    // R1: reset mid-response clears outputs
    @(negedge clk);
    req = 1'b1; addr = 32'h0000_0100; len = 20'd1;
    @(negedge clk);
    req = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears", {done, sel, offset}, '0);
    rst = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule